// File: doc/BRIEF.md
# MDIO Management Master

This block is a bus master for the two-wire management interface that connects a MAC-side host to PHY devices. The host reaches it through a plain synchronous register port with four 32-bit words. One word holds setup and status, one holds the target addresses, one holds the data value, and one holds a 16-bit register address for extended addressing. The block derives the management clock MDC from the system clock through a programmable divider. It shifts out complete management frames on a tri-stated data line and captures the 16 data bits a PHY returns.

A frame starts as a side effect of a register write. Writing the data word sends a write frame. Writing the control word with its read bit set sends a read frame. In extended-addressing mode, writing the address word sends an address frame. While a frame is in flight the busy flag is set and the register port accepts no writes. When a read finds no PHY answering, the error flag is raised and the data word returns all ones.

Top module: `mdio_master`

## Requirements
- R1: Registers are selected by regAddr[3:2]: 0x0 setup/status, 0x4 control, 0x8 data, 0xC extended address. Setup/status bits: bit 0 busy (read-only), bit 1 read error (read-only), bit 6 extended (Clause 45) framing, bits [15:8] half division ratio H, bit 23 falling-edge drive. Control bits: [4:0] device (or Clause 22 register) number, [9:5] port address, bit 15 read start, which always reads back 0. The data and address words use bits [15:0]. Every unlisted bit reads 0, and all registers reset to 0.
- R2: MDC idles high. During a frame, each bit period lasts 2*H system clocks, high for H and then low for H. A programmed H of 0 acts as H = 1.
- R3: A frame has 64 bit periods, sent most significant bit first: 32 ones, a 2-bit start (01 for Clause 22, 00 for Clause 45), a 2-bit opcode, the 5-bit port, the 5-bit device/register number, a 2-bit turnaround and 16 data bits.
- R4: A write to the data word sends a write frame (opcode 01) carrying the written low 16 bits and the port and device fields held in control. The master drives turnaround as 1 then 0.
- R5: With extended framing set, a write to the address word sends an address frame (opcode 00) that carries the written 16 bits. With extended framing clear, the write only stores the value and sends nothing.
- R6: A control write with bit 15 set stores the new port and device fields and sends a read frame (opcode 10 for Clause 22, 11 for Clause 45). From the first turnaround bit onward the master releases the line (mdioOe low, mdioOut low). It samples mdioIn at the end of each bit period, and on completion the data word holds the 16 bits it received.
- R7: If mdioIn is not low at the end of the second turnaround period of a read, the read-error flag is set and the data word becomes 0xFFFF. The flag clears when the next frame starts.
- R8: With falling-edge drive clear, each bit appears on the line at the start of its period, as MDC rises. With it set, each bit appears at the mid-period falling edge of MDC.
- R9: Busy is 1 from the cycle after the starting write for 65 bit periods (the 64 bits plus one idle period with MDC high and the line released). It is 0 after that.
- R10: Writes to any register while busy are ignored: they change no stored value and start no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the register at regAddr (combinational) |
| mdioIn | input | 1 | Sampled level of the management data line |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven on the data line |
| mdioOe | output | 1 | Output enable of the data line driver |

## Verification
On every cycle, the checker asserts four things: MDC stays high and the driver stays off whenever the block is idle, MDC moves only inside a frame, busy rises only after a register write, and the error flag can rise only during a frame. Frame content cannot be checked that way: the bit order, opcode and start encodings, the turnaround release, the placement of each bit for both drive edges, and the division ratio including the zero case. Those are checked by the bench's per-cycle waveform model. The register-level outcomes are checked by the bench's scenarios: captured read data, the all-ones value with its error flag, and writes dropped while busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN    = 32;
  localparam int PAY_W      = 32;
  localparam int FRAME_LEN  = PRE_LEN + PAY_W;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int PAY_IDX_W  = $clog2(PAY_W);
  localparam int TA_IDX     = PRE_LEN + 14;
  localparam int DATA_IDX   = PRE_LEN + 16;

  localparam int CFG_BUSY    = 0;
  localparam int CFG_RDERR   = 1;
  localparam int CFG_C45     = 6;
  localparam int CFG_DIV_LSB = 8;
  localparam int CFG_NEG     = 23;
  localparam int CTL_PORT_LSB = 5;
  localparam int CTL_RD      = 15;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_CTL  = 2'd1,
    REG_DATA = 2'd2,
    REG_ADDR = 2'd3
  } regSel_t;

  typedef struct packed {
    logic             drive;
    logic [IDX_W-1:0] driveIdx;
    logic             sample;
    logic [IDX_W-1:0] sampleIdx;
    logic             done;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             negEdge,
  output logic             busy,
  output logic             mdc,
  output mdioStrobe_t      strobe
);
  localparam int CNT_W = DIV_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] halfC;
  logic [CNT_W-1:0] lastC;
  logic             periodEnd;
  logic             lastBit;

  assign halfC     = (halfDiv == '0) ? CNT_W'(1) : CNT_W'(halfDiv);
  assign lastC     = (halfC << 1) - CNT_W'(1);
  assign periodEnd = (cnt == lastC);
  assign lastBit   = (bitIdx == IDX_W'(FRAME_LEN - 1));

  always_comb begin
    strobe = '0;
    if (state == ST_RUN) begin
      if (negEdge && cnt == halfC - CNT_W'(1)) begin
        strobe.drive    = 1'b1;
        strobe.driveIdx = bitIdx;
      end
      if (periodEnd) begin
        strobe.sample    = 1'b1;
        strobe.sampleIdx = bitIdx;
        if (lastBit) begin
          strobe.done = 1'b1;
        end else if (!negEdge) begin
          strobe.drive    = 1'b1;
          strobe.driveIdx = bitIdx + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      mdc    <= 1'b1;
      busy   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state  <= ST_RUN;
            cnt    <= '0;
            bitIdx <= '0;
            busy   <= 1'b1;
          end
        end
        ST_RUN: begin
          if (periodEnd) begin
            cnt <= '0;
            mdc <= 1'b1;
            if (lastBit) state <= ST_TAIL;
            else bitIdx <= bitIdx + IDX_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == halfC - CNT_W'(1)) mdc <= 1'b0;
          end
        end
        ST_TAIL: begin
          if (periodEnd) begin
            state <= ST_IDLE;
            cnt   <= '0;
            busy  <= 1'b0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 16,
  parameter int FLD_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [3:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             busy,
  input  mdioStrobe_t      strobe,
  input  logic             mdioIn,
  output logic             startReq,
  output logic [DIV_W-1:0] halfDiv,
  output logic             negEdge,
  output logic             readErr,
  output logic             mdioOut,
  output logic             mdioOe
);
  regSel_t           sel;
  logic              c45;
  logic [FLD_W-1:0]  portQ, devQ;
  logic [DATA_W-1:0] dataQ, addrQ, rxShift;
  logic [PAY_W-1:0]  payload, nextPay;
  logic              isRead;
  logic              wrOk, launchAddr, launchWr, launchRd;
  logic [1:0]        stF, opF;
  logic [FLD_W-1:0]  portF, devF;
  logic [PAY_IDX_W-1:0] payIdx;
  logic              unusedIn;

  assign unusedIn = ^{regWrData[31:24], regWrData[22:16], regAddr[1:0]};

  assign sel        = regSel_t'(regAddr[3:2]);
  assign wrOk       = regWrEn && !busy;
  assign launchAddr = wrOk && (sel == REG_ADDR) && c45;
  assign launchWr   = wrOk && (sel == REG_DATA);
  assign launchRd   = wrOk && (sel == REG_CTL) && regWrData[CTL_RD];
  assign startReq   = launchAddr || launchWr || launchRd;

  assign portF = launchRd ? regWrData[CTL_PORT_LSB +: FLD_W] : portQ;
  assign devF  = launchRd ? regWrData[FLD_W-1:0] : devQ;
  assign stF   = c45 ? 2'b00 : 2'b01;
  assign opF   = launchAddr ? 2'b00 : launchWr ? 2'b01 : (c45 ? 2'b11 : 2'b10);
  assign nextPay = {stF, opF, portF, devF, 2'b10,
                    launchRd ? {DATA_W{1'b0}} : regWrData[DATA_W-1:0]};
  assign payIdx  = PAY_IDX_W'(IDX_W'(FRAME_LEN - 1) - strobe.driveIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfDiv <= '0;
      c45     <= 1'b0;
      negEdge <= 1'b0;
      portQ   <= '0;
      devQ    <= '0;
      dataQ   <= '0;
      addrQ   <= '0;
      payload <= '0;
      isRead  <= 1'b0;
      readErr <= 1'b0;
      rxShift <= '0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else begin
      if (wrOk) begin
        unique case (sel)
          REG_CFG: begin
            halfDiv <= regWrData[CFG_DIV_LSB +: DIV_W];
            c45     <= regWrData[CFG_C45];
            negEdge <= regWrData[CFG_NEG];
          end
          REG_CTL: begin
            portQ <= regWrData[CTL_PORT_LSB +: FLD_W];
            devQ  <= regWrData[FLD_W-1:0];
          end
          REG_DATA: dataQ <= regWrData[DATA_W-1:0];
          REG_ADDR: addrQ <= regWrData[DATA_W-1:0];
        endcase
      end
      if (startReq) begin
        payload <= nextPay;
        isRead  <= launchRd;
        readErr <= 1'b0;
        mdioOut <= 1'b1;
        mdioOe  <= 1'b1;
      end
      if (strobe.drive) begin
        if (strobe.driveIdx < IDX_W'(PRE_LEN)) begin
          mdioOut <= 1'b1;
          mdioOe  <= 1'b1;
        end else if (isRead && strobe.driveIdx >= IDX_W'(TA_IDX)) begin
          mdioOut <= 1'b0;
          mdioOe  <= 1'b0;
        end else begin
          mdioOut <= payload[payIdx];
          mdioOe  <= 1'b1;
        end
      end
      if (strobe.sample && isRead) begin
        if (strobe.sampleIdx == IDX_W'(TA_IDX + 1) && mdioIn) readErr <= 1'b1;
        if (strobe.sampleIdx >= IDX_W'(DATA_IDX)) rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      end
      if (strobe.done) begin
        mdioOut <= 1'b0;
        mdioOe  <= 1'b0;
        if (isRead) dataQ <= readErr ? {DATA_W{1'b1}} : {rxShift[DATA_W-2:0], mdioIn};
      end
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (sel)
      REG_CFG: begin
        regRdData[CFG_BUSY]  = busy;
        regRdData[CFG_RDERR] = readErr;
        regRdData[CFG_C45]   = c45;
        regRdData[CFG_DIV_LSB +: DIV_W] = halfDiv;
        regRdData[CFG_NEG]   = negEdge;
      end
      REG_CTL: begin
        regRdData[FLD_W-1:0] = devQ;
        regRdData[CTL_PORT_LSB +: FLD_W] = portQ;
      end
      REG_DATA: regRdData[DATA_W-1:0] = dataQ;
      REG_ADDR: regRdData[DATA_W-1:0] = addrQ;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        mdioIn,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe
);
  logic             busy;
  logic             startReq;
  logic [DIV_W-1:0] halfDiv;
  logic             negEdge;
  logic             readErr;
  mdioStrobe_t      strobe;

  mdio_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
    .strobe(strobe), .mdioIn(mdioIn), .startReq(startReq),
    .halfDiv(halfDiv), .negEdge(negEdge), .readErr(readErr),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .halfDiv(halfDiv),
    .negEdge(negEdge), .busy(busy), .mdc(mdc), .strobe(strobe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic busy,
  input logic mdc,
  input logic mdioOe,
  input logic readErr
);
  a_r2_mdc_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> mdc);

  a_r2_mdc_moves_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdc) |-> busy);

  a_r9_line_released_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

  a_r9_busy_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn));

  a_r7_err_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readErr) |-> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .busy(busy),
  .mdc(mdc), .mdioOe(mdioOe), .readErr(readErr)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdioIn = 1'b1;
  logic        mdc, mdioOut, mdioOe;

  always #4 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  bit        active = 0;
  int        launchAt = 0;
  int        halfM = 1;
  bit        negM = 0;
  bit        readM = 0;
  bit        frameBits [64];
  bit        phyPresent = 1;
  logic [15:0] phyData = '0;
  int        c, p, w, k, h2;
  logic      eMdc, eOut, eOe, eBusy;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic buildFrame(bit [1:0] st, bit [1:0] op, bit [4:0] port,
                            bit [4:0] dev, bit [15:0] data);
    bit [31:0] pay;
    pay = {st, op, port, dev, 2'b10, data};
    for (int i = 0; i < 32; i++) frameBits[i] = 1'b1;
    for (int i = 0; i < 32; i++) frameBits[32 + i] = pay[31 - i];
  endtask

  // per-cycle waveform comparison and PHY responder
  always @(negedge clk) begin
    if (rstN) begin
      eMdc = 1'b1; eOut = 1'b0; eOe = 1'b0; eBusy = 1'b0;
      if (active) begin
        c  = cyc - launchAt;
        h2 = 2 * halfM;
        if (c < 64 * h2) begin
          p = c / h2;
          w = c % h2;
          eMdc = (w < halfM);
          k = negM ? ((w >= halfM) ? p : p - 1) : p;
          if (k < 0) begin eOut = 1'b1; eOe = 1'b1; end
          else if (readM && k >= 46) begin eOut = 1'b0; eOe = 1'b0; end
          else begin eOut = frameBits[k]; eOe = 1'b1; end
          eBusy = 1'b1;
          if (!readM || p == 46) mdioIn = 1'b1;
          else if (p == 47) mdioIn = !phyPresent;
          else if (p >= 48) mdioIn = phyPresent ? phyData[63 - p] : 1'b1;
          else mdioIn = 1'b1;
        end else if (c < 65 * h2) begin
          eBusy = 1'b1;
          mdioIn = 1'b1;
        end else begin
          active = 0;
          mdioIn = 1'b1;
        end
      end
      // R2/R3/R8/R9 waveform compare
      if (regAddr == 4'h0)
        check("R2/R3/R8/R9", "mdc,out,oe,busy", {mdc, mdioOut, mdioOe, regRdData[0]},
              {eMdc, eOut, eOe, eBusy});
      else
        check("R2/R3/R8", "mdc,out,oe", {mdc, mdioOut, mdioOe}, {eMdc, eOut, eOe});
    end
  end

  task automatic wrReg(logic [3:0] a, logic [31:0] d, bit launches);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = 4'h0;
    if (launches) begin
      launchAt = cyc;
      active = 1;
    end
  endtask

  task automatic rdReg(logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; #1;
    d = regRdData;
    regAddr = 4'h0;
  endtask

  task automatic waitIdle();
    while (active) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic setCfg(int div, bit c45, bit neg);
    wrReg(4'h0, (32'(neg) << 23) | (32'(div) << 8) | (32'(c45) << 6), 0);
    halfM = (div == 0) ? 1 : div;
    negM = neg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    rdReg(4'h0, v); check("R1", "reset cfg", v, 0);
    rdReg(4'h4, v); check("R1", "reset ctl", v, 0);
    rdReg(4'h8, v); check("R1", "reset data", v, 0);
    rdReg(4'hC, v); check("R1", "reset addr", v, 0);
    check("R2", "reset mdc", mdc, 1);

    // R1 config readback, Clause 22, rising-edge drive, H=2
    setCfg(2, 0, 0);
    rdReg(4'h0, v); check("R1", "cfg readback", v, 32'h200);
    wrReg(4'h4, (5 << 5) | 32'h11, 0);
    rdReg(4'h4, v); check("R1", "ctl readback", v, 32'hB1);

    // R4 Clause 22 write frame
    readM = 0;
    buildFrame(2'b01, 2'b01, 5'd5, 5'h11, 16'hA5C3);
    wrReg(4'h8, 32'hFFFF_A5C3, 1);
    rdReg(4'h0, v); check("R9", "busy during frame", v[0], 1);
    // R10 writes while busy are dropped
    wrReg(4'h4, 32'h8000 | (9 << 5) | 3, 0);
    wrReg(4'h8, 32'h1111, 0);
    wrReg(4'h0, 32'h0000_0500, 0);
    waitIdle();
    rdReg(4'h0, v); check("R9", "busy clear after frame", v[0], 0);
    rdReg(4'h0, v); check("R10", "cfg unchanged", v, 32'h200);
    rdReg(4'h4, v); check("R10", "ctl unchanged", v, 32'hB1);
    rdReg(4'h8, v); check("R10", "data unchanged", v, 32'hA5C3);

    // R6 Clause 22 read, PHY present
    readM = 1; phyPresent = 1; phyData = 16'h1234;
    buildFrame(2'b01, 2'b10, 5'd3, 5'd2, 16'h0);
    wrReg(4'h4, 32'h8000 | (3 << 5) | 2, 1);
    waitIdle();
    rdReg(4'h8, v); check("R6", "read data", v, 32'h1234);
    rdReg(4'h0, v); check("R6", "no read error", v[1], 0);
    rdReg(4'h4, v); check("R1", "read bit reads zero", v, 32'h62);

    // R7 missing PHY
    phyPresent = 0;
    wrReg(4'h4, 32'h8000 | (3 << 5) | 2, 1);
    waitIdle();
    rdReg(4'h8, v); check("R7", "all ones on no response", v, 32'hFFFF);
    rdReg(4'h0, v); check("R7", "error flag set", v[1], 1);
    phyPresent = 1; phyData = 16'hC0DE;
    wrReg(4'h4, 32'h8000 | (3 << 5) | 2, 1);
    waitIdle();
    rdReg(4'h0, v); check("R7", "error flag cleared", v[1], 0);
    rdReg(4'h8, v); check("R6", "second read data", v, 32'hC0DE);

    // R5 address write in Clause 22 only stores
    readM = 0;
    wrReg(4'hC, 32'h4321, 0);
    repeat (10) @(posedge clk);
    rdReg(4'hC, v); check("R5", "addr stored", v, 32'h4321);
    rdReg(4'h0, v); check("R5", "no frame started", v[0], 0);

    // Clause 45, falling-edge drive, divider 0 (H=1)
    setCfg(0, 1, 1);
    rdReg(4'h0, v); check("R1", "cfg c45 neg", v, 32'h0080_0040);
    wrReg(4'h4, (5'h1F << 5) | 5'h07, 0);
    readM = 0;
    buildFrame(2'b00, 2'b00, 5'h1F, 5'h07, 16'hBEEF);
    wrReg(4'hC, 32'hBEEF, 1);   // R5 address frame, R8 falling edge
    waitIdle();
    buildFrame(2'b00, 2'b01, 5'h1F, 5'h07, 16'h5A5A);
    wrReg(4'h8, 32'h5A5A, 1);   // R4 Clause 45 write
    waitIdle();
    readM = 1; phyData = 16'h0F0F;
    buildFrame(2'b00, 2'b11, 5'h1F, 5'h07, 16'h0);
    wrReg(4'h4, 32'h8000 | (5'h1F << 5) | 5'h07, 1);
    waitIdle();
    rdReg(4'h8, v); check("R6", "c45 read data", v, 32'h0F0F);

    // R2 odd half-ratio, Clause 22 rising-edge
    setCfg(3, 0, 0);
    readM = 0;
    buildFrame(2'b01, 2'b01, 5'h1F, 5'h07, 16'h0001);
    wrReg(4'h8, 32'h0001, 1);
    waitIdle();
    rdReg(4'h8, v); check("R4", "data after write", v, 32'h0001);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule